// File: doc/BRIEF.md
# Modem Status Change Detector

This block produces the eight-bit modem status word of a serial port. It watches four active-low modem lines: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a synchronizer. The upper nibble of the word shows the asserted state of each line. The lower nibble holds sticky change flags, which the host clears by reading the word.

A modem-status interrupt request is raised while any change flag is set and the host has enabled that interrupt source. For self-test, a loopback input replaces the four pins with four modem-control bits. A status change caused by that switch is reported like any other change.

The ring flag differs from the other three flags. It records only the end of a ring, which is the pin returning high. The other flags record a change in either direction.

Top module: `modem_status_unit`

## Requirements
- R1: After reset with all pins high, loopback off and the control bits at 0, `msr_o` is 0x00 and `irq_o` is 0.
- R2: Status bit 4 is DSR, bit 5 is CTS, bit 6 is RI and bit 7 is CD. Each bit is 1 while its pin is low, when loopback is off.
- R3: A pin change reaches `msr_o` after exactly three rising clock edges: two synchronizer stages and the status register.
- R4: Change flag bit 0 (CTS), bit 1 (DSR) and bit 3 (CD) set on a change of their status bit in either direction.
- R5: Change flag bit 2 (RI) sets only when the RI status bit goes from 1 to 0, which means the pin returns high. When the status bit goes from 0 to 1, the flag is unchanged.
- R6: The change flags stay set until a clock edge with `rd_stb_i` high, which clears them. The status bits in the upper nibble are unaffected by the read.
- R7: A change that reaches the status register on the same edge as a read leaves its flag set.
- R8: `irq_o` is high exactly while `msi_en_i` is 1 and at least one change flag is set. It follows `msi_en_i` without delay.
- R9: With `loopback_i` high, the status bits come from `mcr_i` one edge after the control bits are driven, and the pins have no effect. The mapping is DSR from bit 0, CTS from bit 1, RI from bit 2 and CD from bit 3.
- R10: Entering or leaving loopback sets the change flags of every status bit whose level differs between the two sources. For RI, the flag sets only on a fall of the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low |
| ri_ni | input | 1 | Ring indicator pin, active low |
| cd_ni | input | 1 | Carrier detect pin, active low |
| loopback_i | input | 1 | Selects the control bits as the status source |
| mcr_i | input | 4 | Modem control bits: 0 DTR, 1 RTS, 2 OP1, 3 OP2 |
| rd_stb_i | input | 1 | Host read of the status word; clears the change flags |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| msr_o | output | 8 | Status word: change flags [3:0], levels [7:4] |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
A host read can fall in the same cycle as a line change, so a flag clear and a flag set compete on one edge. The bench provokes this in two ways. In a directed case, it times a read strobe onto the exact edge where a synchronized DSR change arrives. In a sweep, it pairs every old and new pin pattern with a read pattern that often coincides with the arriving changes. A surviving flag is judged against a bench model that gives a set priority over the clear. The same model also covers the second overlap: a loopback switch that lands during a read.

// File: rtl/msu_pkg.sv
package msu_pkg;
  localparam int NUM_LINES = 4;
  localparam int SYNC_STAGES = 2;

  // line index = change flag position
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_CD  = 3;

  localparam int MSR_W = 2 * NUM_LINES;

  typedef enum logic {EDGE_ANY = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;

  function automatic edge_kind_e line_edge(input int idx);
    return (idx == LN_RI) ? EDGE_FALL : EDGE_ANY;
  endfunction

  // control bit driving each line in loopback
  function automatic int lb_src(input int idx);
    case (idx)
      LN_CTS:  return 1;
      LN_DSR:  return 0;
      LN_RI:   return 2;
      default: return 3;
    endcase
  endfunction

  // status word position of each line level
  function automatic int lvl_pos(input int idx);
    case (idx)
      LN_CTS:  return 5;
      LN_DSR:  return 4;
      LN_RI:   return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
  parameter int   WIDTH   = 4,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= {WIDTH{RST_VAL}};
      else         stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/msu_src_sel.sv
module msu_src_sel
  import msu_pkg::*;
#(
  parameter int N = NUM_LINES
) (
  input  logic         loopback_i,
  input  logic [N-1:0] pin_act_i,
  input  logic [N-1:0] mcr_i,
  output logic [N-1:0] lvl_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    localparam int SRC = lb_src(i);
    assign lvl_o[i] = loopback_i ? mcr_i[SRC] : pin_act_i[i];
  end
endmodule

// File: rtl/msu_delta.sv
module msu_delta
  import msu_pkg::*;
#(
  parameter int N = NUM_LINES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic         rd_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] delta_o
);
  logic [N-1:0] lvl_q, delta_q, set_vec, delta_d;

  for (genvar i = 0; i < N; i++) begin : g_line
    localparam edge_kind_e KIND = line_edge(i);
    if (KIND == EDGE_FALL) begin : g_fall
      assign set_vec[i] = lvl_q[i] & ~lvl_i[i];

      // R5: a rising status bit leaves a clear flag clear
      p_rise_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lvl_q[i] && lvl_i[i] && !delta_q[i]) |=> !delta_q[i]);
    end else begin : g_any
      assign set_vec[i] = lvl_q[i] ^ lvl_i[i];

      // R4: any change sets the flag
      p_any_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_q[i] != lvl_i[i]) |=> delta_q[i]);
    end

    // R6: flag holds until read
    p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (delta_q[i] && !rd_i) |=> delta_q[i]);

    // R7: set wins over clear
    p_collide_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && (lvl_q[i] != lvl_i[i]) && lvl_q[i]) |=> delta_q[i]);
  end

  // set takes priority over a coincident read
  assign delta_d = (delta_q & {N{~rd_i}}) | set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= lvl_i;
      delta_q <= delta_d;
    end
  end

  // R6: a quiet read clears every flag
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && lvl_i == lvl_q) |=> delta_q == '0);

  // R6: read leaves the levels alone
  p_lvl_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && $stable(lvl_i)) |=> lvl_q == $past(lvl_q));

  assign lvl_o   = lvl_q;
  assign delta_o = delta_q;
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cts_ni,
  input  logic             dsr_ni,
  input  logic             ri_ni,
  input  logic             cd_ni,
  input  logic             loopback_i,
  input  logic [3:0]       mcr_i,
  input  logic             rd_stb_i,
  input  logic             msi_en_i,
  output logic [MSR_W-1:0] msr_o,
  output logic             irq_o
);
  logic [NUM_LINES-1:0] pin_raw_n, pin_sync_n, pin_act, lvl_cur, lvl_q, delta_q;

  assign pin_raw_n[LN_CTS] = cts_ni;
  assign pin_raw_n[LN_DSR] = dsr_ni;
  assign pin_raw_n[LN_RI]  = ri_ni;
  assign pin_raw_n[LN_CD]  = cd_ni;

  msu_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw_n),
    .q_o   (pin_sync_n)
  );

  assign pin_act = ~pin_sync_n;

  msu_src_sel #(.N(NUM_LINES)) u_src (
    .loopback_i(loopback_i),
    .pin_act_i (pin_act),
    .mcr_i     (mcr_i),
    .lvl_o     (lvl_cur)
  );

  msu_delta #(.N(NUM_LINES)) u_delta (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_cur),
    .rd_i   (rd_stb_i),
    .lvl_o  (lvl_q),
    .delta_o(delta_q)
  );

  always_comb begin
    msr_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      msr_o[i]          = delta_q[i];
      msr_o[lvl_pos(i)] = lvl_q[i];
    end
  end

  assign irq_o = msi_en_i & (|delta_q);

  // R8: disabled source never requests
  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msi_en_i |-> !irq_o);

  // R8: request only with a pending flag
  p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (msr_o[NUM_LINES-1:0] != '0));

  // R9: loopback level follows control bits after one edge
  p_lb_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loopback_i |=> (msr_o[5] == $past(mcr_i[1])) && (msr_o[4] == $past(mcr_i[0]))
                   && (msr_o[6] == $past(mcr_i[2])) && (msr_o[7] == $past(mcr_i[3])));
endmodule

// File: tb/modem_status_unit_tb.sv
module modem_status_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_n = 4'hF;   // {cd, ri, dsr, cts}
  logic       lb = 1'b0;
  logic [3:0] mcr = 4'h0;
  logic       rd = 1'b0;
  logic       en = 1'b0;
  logic [7:0] msr;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_unit u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cts_ni    (pin_n[0]),
    .dsr_ni    (pin_n[1]),
    .ri_ni     (pin_n[2]),
    .cd_ni     (pin_n[3]),
    .loopback_i(lb),
    .mcr_i     (mcr),
    .rd_stb_i  (rd),
    .msi_en_i  (en),
    .msr_o     (msr),
    .irq_o     (irq)
  );

  // reference from the requirements (line order CTS, DSR, RI, CD)
  logic [3:0] m_s1, m_s2, m_lvl, m_dlt, m_cur, m_set;
  always_comb begin
    m_cur = lb ? {mcr[3], mcr[2], mcr[0], mcr[1]} : ~m_s2;
    m_set[0] = m_cur[0] ^ m_lvl[0];
    m_set[1] = m_cur[1] ^ m_lvl[1];
    m_set[2] = m_lvl[2] & ~m_cur[2];
    m_set[3] = m_cur[3] ^ m_lvl[3];
  end
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 4'hF; m_s2 <= 4'hF; m_lvl <= 4'h0; m_dlt <= 4'h0;
    end else begin
      m_s1 <= pin_n; m_s2 <= m_s1; m_lvl <= m_cur;
      m_dlt <= (rd ? 4'h0 : m_dlt) | m_set;
    end
  end
  wire [7:0] exp_msr = {m_lvl[3], m_lvl[2], m_lvl[0], m_lvl[1], m_dlt};
  wire       exp_irq = en & (|m_dlt);

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog: cycles %0d, expected below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {irq,msr}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmp_model(input string tag);
    chk(tag, {irq, msr}, {exp_irq, exp_msr});
  endtask

  task automatic do_read();
    rd = 1'b1; step(); rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", {irq, msr}, 9'h000);

    // R3 latency of a CTS assertion
    pin_n[0] = 1'b0;
    step(); chk("R3 edge1", {1'b0, msr}, 9'h000);
    step(); chk("R3 edge2", {1'b0, msr}, 9'h000);
    step(); chk("R3 edge3 R2 R4", {1'b0, msr}, 9'h021);

    // R8 enable gating, combinational
    chk("R8 disabled", {8'h0, irq}, 9'h000);
    en = 1'b1; #1;
    chk("R8 enabled", {8'h0, irq}, 9'h001);
    @(negedge clk);

    // R6 read clears flags, levels stay
    do_read();
    chk("R6 read clear", {irq, msr}, 9'h020);

    // R5 RI asserting: no flag; RI releasing: flag
    pin_n[2] = 1'b0;
    repeat (3) step();
    chk("R5 ring start", {irq, msr}, 9'h060);
    pin_n[2] = 1'b1;
    repeat (3) step();
    chk("R5 ring end", {irq, msr}, 9'h124);

    // R7 read coinciding with arriving DSR change
    do_read();
    chk("R6 read clear 2", {irq, msr}, 9'h020);
    pin_n[1] = 1'b0;
    step(); step();
    rd = 1'b1; step(); rd = 1'b0;
    chk("R7 set beats clear", {irq, msr}, 9'h132);

    // R9 R10 enter loopback: DSR from DTR only
    lb = 1'b1; mcr = 4'b0001;
    step();
    chk("R9 R10 enter loopback", {irq, msr}, 9'h113);
    pin_n = 4'b0101;
    repeat (4) step();
    chk("R9 pins ignored", {irq, msr}, 9'h113);
    do_read();
    chk("R6 read in loopback", {irq, msr}, 9'h010);
    mcr = 4'b1110;
    step();
    chk("R9 map RTS OP1 OP2", {irq, msr}, 9'h1EB);
    do_read();

    // R10 leave loopback: pins CTS off, DSR on, RI off, CD on
    lb = 1'b0;
    step();
    chk("R10 leave loopback", {irq, msr}, 9'h197);
    do_read();
    pin_n = 4'hF;
    repeat (4) step();
    do_read();

    // sweep all pin pattern pairs with interleaved reads (R2 R3 R4 R5 R6 R7 R8)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        en = b[0];
        pin_n = a[3:0];
        for (int k = 0; k < 4; k++) begin
          rd = ((a * 7 + b + k) % 5 == 0);
          step();
          cmp_model("R2 R4 R6 sweep");
        end
        pin_n = b[3:0];
        for (int k = 0; k < 4; k++) begin
          rd = ((a + b * 3 + k) % 3 == 0);
          step();
          cmp_model("R3 R5 R7 R8 sweep");
        end
      end
    end
    rd = 1'b0;

    // loopback sweep with source switches (R9 R10)
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        lb  = (p % 4 != 0);
        mcr = m[3:0] ^ p[3:0];
        pin_n = p[3:0];
        en = m[1];
        rd = ((m + p) % 4 == 1);
        step();
        cmp_model("R9 R10 loopback sweep");
      end
    end
    rd = 1'b0;
    lb = 1'b0;
    repeat (4) step();
    cmp_model("R6 final");

    finish_run();
  end
endmodule